// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a software-visible control register and the bit-level engine of an I2C interface that can act as master or slave. Software writes a mode-select bit, a repeated-start bit, an acknowledge enable and two interrupt enables. The block turns those writes into single-cycle command pulses for the engine: start, repeated start and stop. It also gives a strobe that loads the address byte for sending, and a level that tells the engine whether to acknowledge received data bytes.

The engine reports bus busy, transfer direction, addressed-as-slave, arbitration loss, bus error and byte completion. From these inputs the block keeps the master/slave mode bit and a pending-interrupt flag, and raises an interrupt request. If a start is requested while another master owns the bus, the request is held until the bus is free. If the interface is addressed as a slave transmitter in the meantime, the held request is dropped. Writes that act on a master interrupt (stop or repeated start) also clear the pending-interrupt flag.

All control state is cleared by a synchronous, active-high reset. A write is taken on a clock edge where `wrEn` is 1, and on such a write every write bit is applied together.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After a synchronous reset, modeSel, ackEn, intPending and intReq are 0, and no command pulse is given until a write or a status event occurs.
- R2: Writing modeSel=1 while modeSel is 0 and busBusy is 0 makes startCmd and loadAddr 1 for exactly one cycle, starting the cycle after the write, and modeSel reads 1 from that cycle on.
- R3: Writing modeSel=1 while modeSel is 0, busBusy is 1 and txDir is 0 sets modeSel to 1 and holds the start. startCmd and loadAddr stay 0 while busBusy is 1, and they pulse once in the cycle after the first edge on which busBusy is sampled 0.
- R4: If addrSlave=1 and txDir=1 are sampled while a start is held, the held start is dropped and modeSel returns to 0. No startCmd follows when the bus becomes free.
- R5: Writing modeSel=0 while modeSel=1 and intPending=1 gives a one-cycle stopCmd, clears intPending and makes modeSel read 0 in the next cycle. Being addressed as a slave receiver (addrSlave=1, txDir=0) while a start is held does not drop the held start.
- R6: arbLost sampled while modeSel=1 and no start is held clears modeSel in the next cycle. That cycle gives no command pulse, and the hardware never sets modeSel.
- R7: Writing repeated-start=1 together with modeSel=1, while modeSel=1 and intPending=1, gives a one-cycle repStartCmd and clears intPending. Otherwise a repeated-start write gives no pulse and leaves intPending unchanged.
- R8: ackEn changes only on a write, and it then takes the written wrAckEn value.
- R9: intReq is 1 exactly when (intPending and the general interrupt enable) or (busErr and the bus-error enable). busErr acts on intReq in the same cycle.
- R10: intPending is set in the cycle after byteDone or arbLost is sampled 1. Setting wins over a command's clear in the same cycle.
- R11: Writing modeSel=1 while busBusy=1 and txDir=1 is ignored: modeSel stays 0 and no start is held or issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Control register write strobe |
| wrModeSel | input | 1 | Written mode-select value (1 = master) |
| wrRepStart | input | 1 | Written repeated-start request |
| wrAckEn | input | 1 | Written acknowledge enable |
| wrIntEn | input | 1 | Written general interrupt enable |
| wrBusErrIe | input | 1 | Written bus-error interrupt enable |
| busBusy | input | 1 | Engine: bus is occupied |
| txDir | input | 1 | Engine: interface is transmitting |
| addrSlave | input | 1 | Engine: addressed as slave |
| arbLost | input | 1 | Engine: arbitration lost pulse |
| busErr | input | 1 | Engine: bus error flag |
| byteDone | input | 1 | Engine: byte transfer complete pulse |
| modeSel | output | 1 | Mode-select read-back |
| startCmd | output | 1 | Start condition command pulse |
| repStartCmd | output | 1 | Repeated start command pulse |
| stopCmd | output | 1 | Stop condition command pulse |
| loadAddr | output | 1 | Load address byte for sending pulse |
| ackEn | output | 1 | Acknowledge received data bytes |
| intPending | output | 1 | Pending interrupt flag |
| intReq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the three command pulses never overlap and that a start never repeats on back-to-back cycles. They also check that a held start stays quiet while the bus is busy, that an arbitration loss or a slave-transmitter address clears the mode bit, and that a repeated start only leaves during a master interrupt. Further checks cover a set of intPending after each byteDone, a raised intReq on an enabled bus error, and a steady ackEn between writes. Whether a deferred start fires exactly once after a slave-receiver transfer, and whether ignored writes really leave the state untouched, only the bench's scenarios can show. The same holds for the way write-side and status-side events combine on a shared edge; the bench compares each of these against its cycle model.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  // Strobes from the control side to the datapath, valid for one cycle
  typedef struct packed {
    logic start;
    logic repStart;
    logic stop;
    logic clrInt;
  } seqStrobe_t;

endpackage

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
  import i2c_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       wrModeSel,
  input  logic       wrRepStart,
  input  logic       busBusy,
  input  logic       txDir,
  input  logic       addrSlave,
  input  logic       arbLost,
  input  logic       intFlag,
  output logic       modeSel,
  output seqStrobe_t strobe
);

  logic modeQ, pendQ, modeD, pendD;
  logic sendingMaster, lossEv, swClear, swStart, pendFire, pendDrop;

  assign sendingMaster = modeQ && !pendQ;
  assign lossEv        = arbLost && sendingMaster;
  assign swClear       = wrEn && !wrModeSel && modeQ;
  assign swStart       = wrEn && wrModeSel && !modeQ;
  assign pendDrop      = pendQ && addrSlave && txDir;
  assign pendFire      = pendQ && !busBusy && !(addrSlave && txDir);

  always_comb begin
    strobe.start    = !lossEv && !swClear && ((swStart && !busBusy) || pendFire);
    strobe.stop     = !lossEv && swClear && intFlag;
    strobe.repStart = !lossEv && wrEn && wrModeSel && wrRepStart
                      && sendingMaster && intFlag;
    strobe.clrInt   = strobe.stop || strobe.repStart;
  end

  always_comb begin
    modeD = modeQ;
    pendD = pendQ;
    if (pendDrop) begin
      modeD = 1'b0;
      pendD = 1'b0;
    end else if (pendFire) begin
      pendD = 1'b0;
    end
    if (swStart) begin
      if (!busBusy) begin
        modeD = 1'b1;
      end else if (!txDir) begin
        modeD = 1'b1;
        pendD = 1'b1;
      end
    end
    if (swClear || lossEv) begin
      modeD = 1'b0;
      pendD = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      modeQ <= modeD;
      pendQ <= pendD;
    end
  end

  assign modeSel = modeQ;

  // R3: a held start stays quiet while the bus is occupied
  a_r3_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    pendQ && busBusy |-> !strobe.start);

  // R4: slave-transmitter address drops the held start and the mode bit
  a_r4_drop_pending: assert property (@(posedge clk) disable iff (rst)
    pendQ && addrSlave && txDir |=> !modeQ && !pendQ);

  // R6: arbitration loss while sending clears mode-select
  a_r6_loss_clears_mode: assert property (@(posedge clk) disable iff (rst)
    arbLost && modeQ && !pendQ |=> !modeQ);

  // R7: repeated start only during a master interrupt
  a_r7_rep_needs_master: assert property (@(posedge clk) disable iff (rst)
    strobe.repStart |-> modeQ && intFlag);

endmodule

// File: rtl/i2c_seq_dp.sv
module i2c_seq_dp
  import i2c_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic       wrAckEn,
  input  logic       wrIntEn,
  input  logic       wrBusErrIe,
  input  logic       byteDone,
  input  logic       arbLost,
  input  logic       busErr,
  input  seqStrobe_t strobe,
  output logic       startCmd,
  output logic       repStartCmd,
  output logic       stopCmd,
  output logic       loadAddr,
  output logic       ackEn,
  output logic       intPending,
  output logic       intReq
);

  logic intEnQ, busErrIeQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      ackEn     <= 1'b0;
      intEnQ    <= 1'b0;
      busErrIeQ <= 1'b0;
    end else if (wrEn) begin
      ackEn     <= wrAckEn;
      intEnQ    <= wrIntEn;
      busErrIeQ <= wrBusErrIe;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      intPending <= 1'b0;
    end else if (byteDone || arbLost) begin
      intPending <= 1'b1;
    end else if (strobe.clrInt) begin
      intPending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      startCmd    <= 1'b0;
      loadAddr    <= 1'b0;
      repStartCmd <= 1'b0;
      stopCmd     <= 1'b0;
    end else begin
      startCmd    <= strobe.start;
      loadAddr    <= strobe.start;
      repStartCmd <= strobe.repStart;
      stopCmd     <= strobe.stop;
    end
  end

  assign intReq = (intPending && intEnQ) || (busErr && busErrIeQ);

  // R1: command pulses never overlap
  a_r1_one_command: assert property (@(posedge clk) disable iff (rst)
    $onehot0({startCmd, repStartCmd, stopCmd}));

  // R2: start is a single-cycle pulse
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (rst)
    startCmd |=> !startCmd);

  // R8: acknowledge enable holds between writes
  a_r8_ack_stable: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> $stable(ackEn));

  // R9: an enabled bus error always requests an interrupt
  a_r9_berr_req: assert property (@(posedge clk) disable iff (rst)
    busErr && busErrIeQ |-> intReq);

  // R10: byte completion or loss sets the pending flag
  a_r10_flag_set: assert property (@(posedge clk) disable iff (rst)
    byteDone || arbLost |=> intPending);

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wrEn,
  input  logic wrModeSel,
  input  logic wrRepStart,
  input  logic wrAckEn,
  input  logic wrIntEn,
  input  logic wrBusErrIe,
  input  logic busBusy,
  input  logic txDir,
  input  logic addrSlave,
  input  logic arbLost,
  input  logic busErr,
  input  logic byteDone,
  output logic modeSel,
  output logic startCmd,
  output logic repStartCmd,
  output logic stopCmd,
  output logic loadAddr,
  output logic ackEn,
  output logic intPending,
  output logic intReq
);

  seqStrobe_t strobe;

  i2c_seq_ctrl i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wrEn       (wrEn),
    .wrModeSel  (wrModeSel),
    .wrRepStart (wrRepStart),
    .busBusy    (busBusy),
    .txDir      (txDir),
    .addrSlave  (addrSlave),
    .arbLost    (arbLost),
    .intFlag    (intPending),
    .modeSel    (modeSel),
    .strobe     (strobe)
  );

  i2c_seq_dp i_dp (
    .clk         (clk),
    .rst         (rst),
    .wrEn        (wrEn),
    .wrAckEn     (wrAckEn),
    .wrIntEn     (wrIntEn),
    .wrBusErrIe  (wrBusErrIe),
    .byteDone    (byteDone),
    .arbLost     (arbLost),
    .busErr      (busErr),
    .strobe      (strobe),
    .startCmd    (startCmd),
    .repStartCmd (repStartCmd),
    .stopCmd     (stopCmd),
    .loadAddr    (loadAddr),
    .ackEn       (ackEn),
    .intPending  (intPending),
    .intReq      (intReq)
  );

endmodule

// File: tb/test_i2c_cmd_seq.sv
`timescale 1ns/100ps
module test_i2c_cmd_seq;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 0, wrModeSel = 0, wrRepStart = 0, wrAckEn = 0, wrIntEn = 0, wrBusErrIe = 0;
  logic busBusy = 0, txDir = 0, addrSlave = 0, arbLost = 0, busErr = 0, byteDone = 0;
  logic modeSel, startCmd, repStartCmd, stopCmd, loadAddr, ackEn, intPending, intReq;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  i2c_cmd_seq i_i2c_cmd_seq (.*);

  // ---------------- reference model ----------------
  bit mMode, mPend, mFlag, mAck, mIe, mBe, eStart, eRep, eStop;

  always @(posedge clk) begin
    bit s, r, p, clr, nm, np;
    if (rst) begin
      mMode = 0; mPend = 0; mFlag = 0; mAck = 0; mIe = 0; mBe = 0;
      eStart = 0; eRep = 0; eStop = 0;
    end else begin
      s = 0; r = 0; p = 0; clr = 0; nm = mMode; np = mPend;
      if (mPend) begin
        if (addrSlave && txDir) begin nm = 0; np = 0; end
        else if (!busBusy) begin s = 1; np = 0; end
      end
      if (wrEn) begin
        if (wrModeSel && !mMode) begin
          if (!busBusy) begin s = 1; nm = 1; end
          else if (!txDir) begin nm = 1; np = 1; end
        end else if (!wrModeSel && mMode) begin
          s = 0; nm = 0; np = 0;
          if (mFlag) begin p = 1; clr = 1; end
        end else if (wrModeSel && mMode && !mPend && wrRepStart && mFlag) begin
          r = 1; clr = 1;
        end
        mAck = wrAckEn; mIe = wrIntEn; mBe = wrBusErrIe;
      end
      if (arbLost && mMode && !mPend) begin
        nm = 0; np = 0; s = 0; r = 0; p = 0; clr = 0;
      end
      if (byteDone || arbLost) mFlag = 1;
      else if (clr) mFlag = 0;
      mMode = nm; mPend = np; eStart = s; eRep = r; eStop = p;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every cycle, away from the edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R6 modeSel", modeSel, mMode);
      chk("R2 R3 R4 startCmd", startCmd, eStart);
      chk("R2 loadAddr", loadAddr, eStart);
      chk("R7 repStartCmd", repStartCmd, eRep);
      chk("R5 stopCmd", stopCmd, eStop);
      chk("R8 ackEn", ackEn, mAck);
      chk("R10 intPending", intPending, mFlag);
      chk("R9 intReq", intReq, (mFlag && mIe) || (busErr && mBe));
    end
  end

  task automatic wr(logic m, logic rs, logic a, logic ie, logic be);
    wrEn = 1; wrModeSel = m; wrRepStart = rs; wrAckEn = a; wrIntEn = ie; wrBusErrIe = be;
  endtask

  task automatic endWr();
    wrEn = 0; wrRepStart = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 modeSel", modeSel, 0);
    chk("R1 ackEn", ackEn, 0);
    chk("R1 intPending", intPending, 0);
    chk("R1 intReq", intReq, 0);
    chk("R1 startCmd", startCmd, 0);

    // R8: write enables, then toggle data without wrEn
    #1 wr(0, 0, 1, 1, 0);
    @(negedge clk); chk("R8 ack written", ackEn, 1);
    #1 endWr(); wrAckEn = 0;
    @(negedge clk); chk("R8 ack held without write", ackEn, 1);

    // R2: start from idle
    #1 wr(1, 0, 1, 1, 0);
    @(negedge clk);
    chk("R2 start pulse", startCmd, 1);
    chk("R2 load pulse", loadAddr, 1);
    chk("R2 modeSel set", modeSel, 1);
    #1 endWr();
    @(negedge clk); chk("R2 start one cycle", startCmd, 0);

    // R10 R9: byte done
    #1 byteDone = 1;
    @(negedge clk);
    chk("R10 flag set", intPending, 1);
    chk("R9 intReq from flag", intReq, 1);
    #1 byteDone = 0;

    // R7: repeated start during master interrupt
    wr(1, 1, 1, 1, 0);
    @(negedge clk);
    chk("R7 rep pulse", repStartCmd, 1);
    chk("R7 flag cleared", intPending, 0);
    #1 endWr();

    // R5: stop during master interrupt
    byteDone = 1;
    @(negedge clk); #1 byteDone = 0;
    wr(0, 0, 1, 1, 0);
    @(negedge clk);
    chk("R5 stop pulse", stopCmd, 1);
    chk("R5 modeSel cleared", modeSel, 0);
    chk("R5 flag cleared", intPending, 0);
    #1 endWr();

    // R7 ignored outside master interrupt
    byteDone = 1;
    @(negedge clk); #1 byteDone = 0;
    wr(0, 1, 1, 1, 0);
    @(negedge clk);
    chk("R7 ignored no pulse", repStartCmd, 0);
    chk("R7 ignored flag kept", intPending, 1);
    #1 endWr();

    // R3 and R5: deferred start across a slave-receiver transfer
    busBusy = 1; txDir = 0;
    wr(1, 0, 1, 1, 0);
    @(negedge clk);
    chk("R3 no start while busy", startCmd, 0);
    chk("R3 modeSel pending", modeSel, 1);
    #1 endWr(); addrSlave = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R5 receiver keeps hold", startCmd, 0);
    end
    #1 addrSlave = 0; busBusy = 0;
    @(negedge clk);
    chk("R3 deferred start", startCmd, 1);
    chk("R3 deferred load", loadAddr, 1);

    // R6: arbitration loss
    #1 arbLost = 1;
    @(negedge clk);
    chk("R6 mode cleared", modeSel, 0);
    chk("R6 flag set", intPending, 1);
    #1 arbLost = 0;

    // R4: slave transmitter cancels held start
    busBusy = 1; txDir = 0;
    wr(1, 0, 1, 1, 0);
    @(negedge clk); chk("R4 held", modeSel, 1);
    #1 endWr(); addrSlave = 1; txDir = 1;
    @(negedge clk); chk("R4 mode dropped", modeSel, 0);
    #1 addrSlave = 0; txDir = 0; busBusy = 0;
    repeat (2) begin
      @(negedge clk); chk("R4 no start after free", startCmd, 0);
    end

    // R11: busy while transmitting
    #1 busBusy = 1; txDir = 1;
    wr(1, 0, 1, 1, 0);
    @(negedge clk); chk("R11 mode unchanged", modeSel, 0);
    #1 endWr(); busBusy = 0; txDir = 0;
    repeat (2) begin
      @(negedge clk); chk("R11 no start", startCmd, 0);
    end

    // R9: bus-error gating
    #1 wr(0, 0, 1, 0, 1);
    @(negedge clk); chk("R9 flag masked", intReq, 0);
    #1 endWr(); busErr = 1;
    @(negedge clk); chk("R9 bus error request", intReq, 1);
    #1 wr(0, 0, 1, 0, 0);
    @(negedge clk); chk("R9 bus error masked", intReq, 0);
    #1 endWr(); busErr = 0;

    // R10: set wins over repeated-start clear
    wr(1, 0, 1, 1, 0);
    @(negedge clk); chk("R2 start again", startCmd, 1);
    #1 wr(1, 1, 1, 1, 0); byteDone = 1;
    @(negedge clk);
    chk("R7 rep with flag", repStartCmd, 1);
    chk("R10 set beats clear", intPending, 1);
    #1 endWr(); byteDone = 0;

    repeat (3) @(negedge clk);
    summary();
  end

endmodule